// File: doc/BRIEF.md
# Long-Silence Mute Flag Detector

This block decides when the analog stage after a two-channel audio converter may be muted. It looks at each left/right sample pair when a sample strobe arrives, together with the current output-routing code and the two per-channel attenuation counts. It keeps one saturating run counter of consecutive qualifying strobes. It raises a single registered mute flag once that run reaches 2^RUN_LOG2 strobes, which is 16384 samples by default, or about 0.37 s at 44.1 kHz.

A strobe qualifies when any one of four conditions holds:

- both input channels are all-zero;
- every input channel that the routing code actually sends to an output is all-zero;
- the routing code silences both outputs;
- both attenuation counts read zero.

After reset the flag is held high through an initialisation window of strobes. Only then does normal evaluation begin. The audio path, the attenuation arithmetic and the analog switch are outside this block.

Top module: `silence_mute_detect`

## Requirements
- R1: While `rst` is high, and for the first INIT_STROBES-1 strobes (8 by default) after `rst` falls, `mute_flag` is 1 whatever the other inputs carry.
- R2: Strobe number INIT_STROBES (the 9th) after reset release is the first one evaluated. A non-qualifying 9th strobe drives `mute_flag` to 0 one clock after that strobe.
- R3: `mute_flag` becomes 1 one clock after the N-th consecutive qualifying evaluated strobe, where N = 2^RUN_LOG2. It is still 0 after N-1 such strobes.
- R4: A strobe on which both `smp_left` and `smp_right` are zero qualifies, under every routing code.
- R5: `route_mode[3:2]` selects the left output's source and `route_mode[1:0]` the right output's source, coded 00 silence, 01 right input, 10 left input, 11 average of both. An input channel is watched when either output uses it (code 01 or 11 for the right input, code 10 or 11 for the left input). A strobe whose watched channels are all zero qualifies.
- R6: `route_mode` = 0000 qualifies, whatever the sample data.
- R7: `gain_left` = 0 together with `gain_right` = 0 qualifies. One count at zero alone does not.
- R8: An evaluated strobe that meets none of the conditions clears the run. `mute_flag` is 0 one clock after it.
- R9: The run saturates at N. `mute_flag` stays 1 for every further qualifying strobe and never wraps back to 0.
- R10: Between strobes, changes on the sample, mode and gain inputs have no effect. `mute_flag` and the run change only on clocks where `smp_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-clock strobe marking a valid sample pair |
| smp_left | input | SAMPLE_W | Left input sample, two's complement |
| smp_right | input | SAMPLE_W | Right input sample, two's complement |
| route_mode | input | 4 | Output routing code: [3:2] left output source, [1:0] right output source |
| gain_left | input | GAIN_W | Left attenuation count, 0 means fully attenuated |
| gain_right | input | GAIN_W | Right attenuation count, 0 means fully attenuated |
| mute_flag | output | 1 | Registered analog-mute request |

## Verification
The bench is built with a run length of 8 strobes. It sweeps all sixteen routing codes against all four combinations of zero and non-zero left and right data, and all four combinations of zero and non-zero gain counts. Each combination is held for longer than the run length and then broken by one non-qualifying strobe. This sweep separates the routing-aware watch from the plain both-zero test: for example, right-only silence must mute under routing 0101 but not under 1001. It also separates the both-gains rule from a single zero gain, and shows the threshold, saturation and clearing points.

Further patterns cover other cases:

- Toggling inputs between strobes shows that only strobes count.
- Non-qualifying data across the initialisation window shows the flag is held high and then released on the ninth strobe.
- A reset while the flag is low shows that reset raises it again.

// File: rtl/smd_pkg.sv
package smd_pkg;

  localparam int SRC_W   = 2;
  localparam int NUM_OUT = 2;
  localparam int MODE_W  = SRC_W * NUM_OUT;

  typedef enum logic [SRC_W-1:0] {
    SRC_SILENT = 2'b00,
    SRC_RIGHT  = 2'b01,
    SRC_LEFT   = 2'b10,
    SRC_BLEND  = 2'b11
  } out_src_e;

  typedef struct packed {
    logic both_zero;
    logic routed_zero;
    logic mode_silent;
    logic gain_floor;
  } cond_t;

endpackage

// File: rtl/smd_route_watch.sv
module smd_route_watch
  import smd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 8
) (
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [MODE_W-1:0]   route_mode,
  input  logic [GAIN_W-1:0]   gain_left,
  input  logic [GAIN_W-1:0]   gain_right,
  output cond_t               conds,
  output logic                qualify
);

  logic [NUM_OUT-1:0] uses_l;
  logic [NUM_OUT-1:0] uses_r;
  logic               left_zero;
  logic               right_zero;
  logic               watch_l;
  logic               watch_r;

  // one decoder per output; each output names its own source
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    out_src_e src;
    assign src       = out_src_e'(route_mode[g*SRC_W +: SRC_W]);
    assign uses_l[g] = (src == SRC_LEFT)  || (src == SRC_BLEND);
    assign uses_r[g] = (src == SRC_RIGHT) || (src == SRC_BLEND);
  end

  assign left_zero  = (smp_left  == '0);
  assign right_zero = (smp_right == '0);
  assign watch_l    = |uses_l;
  assign watch_r    = |uses_r;

  always_comb begin
    conds.both_zero   = left_zero && right_zero;
    conds.routed_zero = (!watch_l || left_zero) && (!watch_r || right_zero);
    conds.mode_silent = (route_mode == '0);
    conds.gain_floor  = (gain_left == '0) && (gain_right == '0);
    qualify = conds.both_zero | conds.routed_zero | conds.mode_silent | conds.gain_floor;
  end

endmodule

// File: rtl/smd_init_gate.sv
module smd_init_gate #(
  parameter int INIT_STROBES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic busy,
  output logic eval_stb
);

  localparam int CW = (INIT_STROBES > 2) ? $clog2(INIT_STROBES) : 1;
  localparam logic [CW-1:0] SKIP = CW'(INIT_STROBES - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= SKIP;
    end else if (stb && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy     = (left_q != '0);
  assign eval_stb = stb && !busy;

  AST_INIT_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy); // R2
  AST_INIT_ONLY_STB: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(left_q)); // R10

endmodule

// File: rtl/smd_run_counter.sv
module smd_run_counter #(
  parameter int RUN_LOG2 = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic qualify,
  output logic full_next,
  output logic full
);

  localparam int CW = RUN_LOG2 + 1;
  localparam logic [CW-1:0] LIMIT = CW'(1) << RUN_LOG2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!qualify)            cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = LIMIT;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign full_next = (cnt_d == LIMIT);
  assign full      = (cnt_q == LIMIT);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R9
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (step && !qualify) |=> (cnt_q == '0)); // R8
  AST_RUN_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (step && qualify && full) |=> full); // R9
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/silence_mute_detect.sv
module silence_mute_detect
  import smd_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int GAIN_W       = 8,
  parameter int RUN_LOG2     = 14,
  parameter int INIT_STROBES = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [MODE_W-1:0]   route_mode,
  input  logic [GAIN_W-1:0]   gain_left,
  input  logic [GAIN_W-1:0]   gain_right,
  output logic                mute_flag
);

  cond_t conds;
  logic  qualify;
  logic  init_busy;
  logic  eval_stb;
  logic  run_full_next;
  logic  run_full;
  logic  flag_q;

  smd_route_watch #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W)
  ) u_watch (
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .route_mode (route_mode),
    .gain_left  (gain_left),
    .gain_right (gain_right),
    .conds      (conds),
    .qualify    (qualify)
  );

  smd_init_gate #(
    .INIT_STROBES (INIT_STROBES)
  ) u_init (
    .clk      (clk),
    .rst      (rst),
    .stb      (smp_stb),
    .busy     (init_busy),
    .eval_stb (eval_stb)
  );

  smd_run_counter #(
    .RUN_LOG2 (RUN_LOG2)
  ) u_run (
    .clk       (clk),
    .rst       (rst),
    .step      (eval_stb),
    .qualify   (qualify),
    .full_next (run_full_next),
    .full      (run_full)
  );

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b1;
    else if (smp_stb) flag_q <= init_busy | run_full_next;
  end

  assign mute_flag = flag_q;

  AST_INIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> mute_flag); // R1
  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(mute_flag) |-> run_full); // R3
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(mute_flag)); // R10
  AST_SILENT_MODE_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    (eval_stb && conds.mode_silent && run_full) |=> mute_flag); // R6

endmodule

// File: tb/sim_silence_mute_detect.sv
module sim_silence_mute_detect;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_LOG2   = 3;
  localparam int RUN_N      = 1 << RUN_LOG2;
  localparam int INIT_STB   = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic [3:0]  route_mode = 4'b1001;
  logic [7:0]  gain_left = 8'hff;
  logic [7:0]  gain_right = 8'hff;
  logic        mute_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int init_left = INIT_STB - 1;
  int run = 0;
  bit first_eval = 1;
  bit exp_flag = 1;
  int sidx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  silence_mute_detect #(
    .SAMPLE_W     (16),
    .GAIN_W       (8),
    .RUN_LOG2     (RUN_LOG2),
    .INIT_STROBES (INIT_STB)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .route_mode (route_mode),
    .gain_left  (gain_left),
    .gain_right (gain_right),
    .mute_flag  (mute_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: mute_flag=%0b expected=%0b (strobe %0d)", tag, act, exp, sidx);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R5 watched-channel rule computed from the routing code fields
  function automatic bit qual(input logic [3:0] m, input logic [15:0] l,
                              input logic [15:0] r, input logic [7:0] gl,
                              input logic [7:0] gr, output string why);
    int ls = m[3:2];
    int rs = m[1:0];
    bit wl = (ls >= 2) || (rs >= 2);
    bit wr = (ls % 2 == 1) || (rs % 2 == 1);
    if (m == 0)                   begin why = "R6"; return 1; end
    if (gl == 0 && gr == 0)       begin why = "R7"; return 1; end
    if (l == 0 && r == 0)         begin why = "R4"; return 1; end
    if ((!wl || l == 0) && (!wr || r == 0)) begin why = "R5"; return 1; end
    why = "R8";
    return 0;
  endfunction

  task automatic strobe(input logic [3:0] m, input logic [15:0] l, input logic [15:0] r,
                        input logic [7:0] gl, input logic [7:0] gr);
    string tag;
    string why;
    bit q;
    int prev;
    @(negedge clk);
    route_mode = m; smp_left = l; smp_right = r; gain_left = gl; gain_right = gr;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    sidx++;
    if (init_left > 0) begin
      init_left--;
      exp_flag = 1;
      tag = "R1";
    end else begin
      q = qual(m, l, r, gl, gr, why);
      prev = run;
      run = q ? ((run < RUN_N) ? run + 1 : RUN_N) : 0;
      exp_flag = (run == RUN_N);
      if (first_eval)                        tag = "R2";
      else if (run == RUN_N && prev < RUN_N) tag = "R3";
      else if (run == RUN_N)                 tag = "R9";
      else                                   tag = why;
      first_eval = 0;
    end
    chk(tag, mute_flag, exp_flag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", mute_flag, 1'b1);
    rst = 1'b0;
    init_left = INIT_STB - 1;
    run = 0;
    first_eval = 1;
    exp_flag = 1;
  endtask

  function automatic logic [15:0] nz_l(input int k);
    return k[0] ? 16'h0001 : 16'h8000;
  endfunction

  function automatic logic [15:0] nz_r(input int k);
    return k[0] ? 16'h7fff : 16'h0100;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R1 and R2: initialisation window with loud stereo data
    for (int i = 0; i < INIT_STB; i++)
      strobe(4'b1001, nz_l(i), nz_r(i), 8'hff, 8'hff);

    for (int m = 0; m < 16; m++) begin
      for (int z = 0; z < 4; z++) begin
        for (int gc = 0; gc < 4; gc++) begin
          logic [7:0] gl;
          logic [7:0] gr;
          gl = (gc == 1 || gc == 3) ? 8'h00 : 8'h80;
          gr = (gc == 2 || gc == 3) ? 8'h00 : 8'h01;
          for (int k = 0; k < RUN_N + 2; k++)
            strobe(4'(m), z[0] ? 16'h0000 : nz_l(sidx), z[1] ? 16'h0000 : nz_r(sidx), gl, gr);
          // R10: inputs wiggle without a strobe
          @(negedge clk);
          route_mode = 4'b0000; smp_left = '0; smp_right = '0; gain_left = '0; gain_right = '0;
          repeat (2) @(negedge clk);
          route_mode = 4'b1001; smp_left = 16'h1234; smp_right = 16'h4321;
          gain_left = 8'hff; gain_right = 8'hff;
          @(negedge clk);
          chk("R10", mute_flag, exp_flag);
          // R8: one loud strobe breaks the run
          strobe(4'b1001, nz_l(sidx), nz_r(sidx), 8'hff, 8'h7f);
        end
      end
    end

    // R1: reset while flag is low, then initialisation again
    do_reset();
    for (int i = 0; i < INIT_STB; i++)
      strobe(4'b0110, nz_l(i), nz_r(i), 8'h10, 8'h10);

    finish_run();
  end

endmodule